// File: doc/BRIEF.md
# Accumulator ALU with Packed Status Flags

This block is the arithmetic and logic datapath of an 8-bit accumulator processor, paired with the processor status byte that holds its flags. Each cycle the decoder presents an operation code, a register value (accumulator or index), and a memory operand. The block returns a result word at once and reports new carry, zero, overflow and negative flags. It also returns a write mask that names the flags the operation is allowed to update. When `exec_i` is high, the masked flags are written into the status register on the next clock edge. The carry the operation uses is the one held in that register.

The status register can be loaded whole from a byte, as happens when status is pulled from the stack. It is always visible as a packed byte for pushing. Separate flag commands set or clear carry, interrupt disable and decimal mode, and clear overflow. The decimal flag is stored but has no effect on arithmetic. Add and subtract always work in binary.

Top module: `alu8_core`

## Requirements
- R1: After reset the packed status byte reads 0x24: interrupt disable (bit 2) set, bit 5 set, every other flag clear.
- R2: Op code 0 (add) returns the low bits of reg + mem + C. The new C is bit 8 of the sum. V is set when reg and mem share a sign bit and the result's sign bit differs from reg's. Z and N come from the result. The mask (bit 3 N, bit 2 V, bit 1 Z, bit 0 C) is 0xF.
- R3: Op code 1 (subtract) returns reg − mem − (1 − C). The new C is 1 when no borrow occurred. V is set when reg and mem differ in sign and the result's sign differs from reg's. The mask is 0xF.
- R4: Op codes 2, 3 and 4 return reg AND, OR and XOR mem. Op code 15 passes mem through. All four set Z and N from the result and have mask 0xA.
- R5: Op code 5 (compare) sets C when reg ≥ mem (unsigned) and takes Z and N from the low bits of reg − mem. It returns reg unchanged and has mask 0xB.
- R6: Op code 6 (bit test) sets Z when (reg AND mem) is zero, N from mem bit 7 and V from mem bit 6. It returns reg unchanged and has mask 0xE.
- R7: Op code 7 shifts mem left, moving bit 7 into C. Op code 8 shifts mem right, moving mem bit 0 into C and clearing N. Both have mask 0xB.
- R8: Op code 9 rotates mem left, with C entering bit 0 and bit 7 leaving to C. Op code 10 rotates right, with C entering bit 7 and bit 0 leaving to C. Both have mask 0xB.
- R9: Op codes 11 and 12 return mem + 1 and mem − 1 modulo 256. They have mask 0xA and leave C and V in the status register unchanged.
- R10: With `exec_i` high, only masked flags are written, into status bits 0 (C), 1 (Z), 6 (V) and 7 (N). With `exec_i` low, or for op codes 13 and 14 (mask 0, result = reg), the status byte does not change.
- R11: Flag commands apply on the clock edge and override an operation's write to the same flag. The codes are 1 set C, 2 clear C, 3 set I, 4 clear I, 5 set D, 6 clear D and 7 clear V. A set D leaves add in binary.
- R12: A status load takes bits 0–3, 6 and 7 from the byte and ignores bits 4 and 5. It takes priority over all other updates. The packed output always shows bit 5 as 1 and bit 4 as `push_b_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 4 | Operation code |
| reg_i | input | WIDTH | Register operand (accumulator or index) |
| mem_i | input | WIDTH | Memory operand |
| exec_i | input | 1 | Commit masked flags on the next edge |
| fctl_i | input | 3 | Flag set/clear command |
| ld_i | input | 1 | Load status from `ld_data_i` |
| ld_data_i | input | 8 | Status byte to load |
| push_b_i | input | 1 | Value shown in bit 4 of the packed byte |
| result_o | output | WIDTH | Operation result |
| flags_o | output | 4 | Computed N, V, Z, C (bits 3..0) |
| wmask_o | output | 4 | Flags the operation writes (same order) |
| status_o | output | 8 | Packed status byte |

## Verification
The bench builds the block with the default WIDTH of 8, so the sign bit is bit 7 and the carry is bit 8. This makes the signed-overflow boundaries reachable with byte constants. Examples are 0x7F + carry, 0x50 + 0x50 and 0x50 − 0xB0, along with the 0xFF/0x00 wrap of increment and decrement. At this width the bit-test sources for N and V sit exactly at mem bits 7 and 6.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  typedef enum logic [3:0] {
    OP_ADC  = 4'd0,
    OP_SBC  = 4'd1,
    OP_AND  = 4'd2,
    OP_ORA  = 4'd3,
    OP_EOR  = 4'd4,
    OP_CMP  = 4'd5,
    OP_BIT  = 4'd6,
    OP_ASL  = 4'd7,
    OP_LSR  = 4'd8,
    OP_ROL  = 4'd9,
    OP_ROR  = 4'd10,
    OP_INC  = 4'd11,
    OP_DEC  = 4'd12,
    OP_RSV  = 4'd13,
    OP_NOP  = 4'd14,
    OP_PASS = 4'd15
  } op_e;

  typedef enum logic [2:0] {
    FC_NONE = 3'd0,
    FC_SETC = 3'd1,
    FC_CLRC = 3'd2,
    FC_SETI = 3'd3,
    FC_CLRI = 3'd4,
    FC_SETD = 3'd5,
    FC_CLRD = 3'd6,
    FC_CLRV = 3'd7
  } fctl_e;

  // Flag order inside the packed four-flag vector: n v z c (bit 3 .. bit 0)
  typedef struct packed {
    logic n;
    logic v;
    logic z;
    logic c;
  } flags_t;

  // Status byte bit positions (the stack image depends on these)
  localparam int SB_C = 0;
  localparam int SB_Z = 1;
  localparam int SB_I = 2;
  localparam int SB_D = 3;
  localparam int SB_B = 4;
  localparam int SB_U = 5;
  localparam int SB_V = 6;
  localparam int SB_N = 7;

  localparam logic [3:0] MK_ALL  = 4'b1111;
  localparam logic [3:0] MK_NZ   = 4'b1010;
  localparam logic [3:0] MK_NZC  = 4'b1011;
  localparam logic [3:0] MK_NVZ  = 4'b1110;
  localparam logic [3:0] MK_NONE = 4'b0000;

endpackage

// File: rtl/alu8_arith.sv
module alu8_arith
  import alu8_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  op_e              op_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] m_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o,
  output logic             ovf_o,
  output logic [WIDTH-1:0] step_o
);
  localparam int MSB = WIDTH - 1;

  logic             invert;
  logic             cin_eff;
  logic [WIDTH-1:0] opnd;
  logic [WIDTH:0]   full;

  // Subtract is add of the complement; carry out then means "no borrow".
  always_comb begin
    invert  = (op_i == OP_SBC) || (op_i == OP_CMP);
    cin_eff = (op_i == OP_CMP) ? 1'b1 : cin_i;
    opnd    = invert ? ~m_i : m_i;
    full    = {1'b0, a_i} + {1'b0, opnd} + {{WIDTH{1'b0}}, cin_eff};
    sum_o   = full[MSB:0];
    cout_o  = full[WIDTH];
    ovf_o   = (a_i[MSB] == opnd[MSB]) && (full[MSB] != a_i[MSB]);
    step_o  = (op_i == OP_DEC) ? (m_i - WIDTH'(1)) : (m_i + WIDTH'(1));
  end

endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
  import alu8_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  op_e              op_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] m_i,
  output logic [WIDTH-1:0] res_o,
  output logic [WIDTH-1:0] andv_o
);

  always_comb begin
    andv_o = a_i & m_i;
    unique case (op_i)
      OP_ORA:  res_o = a_i | m_i;
      OP_EOR:  res_o = a_i ^ m_i;
      default: res_o = andv_o;
    endcase
  end

endmodule

// File: rtl/alu8_shift.sv
module alu8_shift
  import alu8_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  op_e              op_i,
  input  logic [WIDTH-1:0] m_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] res_o,
  output logic             cout_o
);

  always_comb begin
    unique case (op_i)
      OP_ASL:  {cout_o, res_o} = {m_i, 1'b0};
      OP_LSR:  {res_o, cout_o} = {1'b0, m_i};
      OP_ROL:  {cout_o, res_o} = {m_i, cin_i};
      OP_ROR:  {res_o, cout_o} = {cin_i, m_i};
      default: begin
        res_o  = m_i;
        cout_o = cin_i;
      end
    endcase
  end

endmodule

// File: rtl/alu8_status.sv
module alu8_status
  import alu8_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       upd_i,
  input  flags_t     fl_i,
  input  flags_t     mk_i,
  input  fctl_e      fctl_i,
  input  logic       ld_i,
  input  logic [7:0] ld_data_i,
  input  logic       push_b_i,
  output logic       c_o,
  output logic       v_o,
  output logic [7:0] byte_o
);

  logic c_q, z_q, i_q, d_q, v_q, n_q;
  logic c_d, z_d, i_d, d_d, v_d, n_d;

  // Next state: operation write, then flag command, then whole-byte load.
  always_comb begin
    c_d = c_q;
    z_d = z_q;
    i_d = i_q;
    d_d = d_q;
    v_d = v_q;
    n_d = n_q;
    if (upd_i) begin
      if (mk_i.c) c_d = fl_i.c;
      if (mk_i.z) z_d = fl_i.z;
      if (mk_i.v) v_d = fl_i.v;
      if (mk_i.n) n_d = fl_i.n;
    end
    unique case (fctl_i)
      FC_SETC: c_d = 1'b1;
      FC_CLRC: c_d = 1'b0;
      FC_SETI: i_d = 1'b1;
      FC_CLRI: i_d = 1'b0;
      FC_SETD: d_d = 1'b1;
      FC_CLRD: d_d = 1'b0;
      FC_CLRV: v_d = 1'b0;
      default: ;
    endcase
    if (ld_i) begin
      c_d = ld_data_i[SB_C];
      z_d = ld_data_i[SB_Z];
      i_d = ld_data_i[SB_I];
      d_d = ld_data_i[SB_D];
      v_d = ld_data_i[SB_V];
      n_d = ld_data_i[SB_N];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_q <= 1'b0;
      z_q <= 1'b0;
      i_q <= 1'b1;
      d_q <= 1'b0;
      v_q <= 1'b0;
      n_q <= 1'b0;
    end else begin
      c_q <= c_d;
      z_q <= z_d;
      i_q <= i_d;
      d_q <= d_d;
      v_q <= v_d;
      n_q <= n_d;
    end
  end

  always_comb begin
    byte_o       = 8'h00;
    byte_o[SB_C] = c_q;
    byte_o[SB_Z] = z_q;
    byte_o[SB_I] = i_q;
    byte_o[SB_D] = d_q;
    byte_o[SB_B] = push_b_i;
    byte_o[SB_U] = 1'b1;
    byte_o[SB_V] = v_q;
    byte_o[SB_N] = n_q;
  end

  assign c_o = c_q;
  assign v_o = v_q;

endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       op_i,
  input  logic [WIDTH-1:0] reg_i,
  input  logic [WIDTH-1:0] mem_i,
  input  logic             exec_i,
  input  logic [2:0]       fctl_i,
  input  logic             ld_i,
  input  logic [7:0]       ld_data_i,
  input  logic             push_b_i,
  output logic [WIDTH-1:0] result_o,
  output logic [3:0]       flags_o,
  output logic [3:0]       wmask_o,
  output logic [7:0]       status_o
);
  localparam int MSB = WIDTH - 1;

  op_e              op;
  logic             c_cur, v_cur;
  logic [WIDTH-1:0] sum, step, lres, andv, sres;
  logic             a_cout, a_ovf, s_cout;
  logic [WIDTH-1:0] res;
  logic [WIDTH-1:0] zn_src;
  flags_t           fl, mk;

  assign op = op_e'(op_i);

  alu8_arith #(.WIDTH(WIDTH)) u_arith (
    .op_i(op), .a_i(reg_i), .m_i(mem_i), .cin_i(c_cur),
    .sum_o(sum), .cout_o(a_cout), .ovf_o(a_ovf), .step_o(step)
  );

  alu8_logic #(.WIDTH(WIDTH)) u_logic (
    .op_i(op), .a_i(reg_i), .m_i(mem_i), .res_o(lres), .andv_o(andv)
  );

  alu8_shift #(.WIDTH(WIDTH)) u_shift (
    .op_i(op), .m_i(mem_i), .cin_i(c_cur), .res_o(sres), .cout_o(s_cout)
  );

  // Result select, flag sourcing and write mask
  always_comb begin
    res    = reg_i;
    zn_src = reg_i;
    mk     = flags_t'(MK_NONE);
    fl.c   = c_cur;
    fl.v   = v_cur;
    unique case (op)
      OP_ADC, OP_SBC: begin
        res  = sum;
        fl.c = a_cout;
        fl.v = a_ovf;
        mk   = flags_t'(MK_ALL);
      end
      OP_AND, OP_ORA, OP_EOR: begin
        res = lres;
        mk  = flags_t'(MK_NZ);
      end
      OP_CMP: begin
        fl.c = a_cout;
        mk   = flags_t'(MK_NZC);
      end
      OP_BIT: begin
        fl.v = mem_i[MSB-1];
        mk   = flags_t'(MK_NVZ);
      end
      OP_ASL, OP_LSR, OP_ROL, OP_ROR: begin
        res  = sres;
        fl.c = s_cout;
        mk   = flags_t'(MK_NZC);
      end
      OP_INC, OP_DEC: begin
        res = step;
        mk  = flags_t'(MK_NZ);
      end
      OP_PASS: begin
        res = mem_i;
        mk  = flags_t'(MK_NZ);
      end
      default: ;
    endcase
    zn_src = (op == OP_CMP) ? sum : res;
    if (op == OP_BIT) begin
      fl.z = (andv == '0);
      fl.n = mem_i[MSB];
    end else begin
      fl.z = (zn_src == '0);
      fl.n = zn_src[MSB];
    end
  end

  alu8_status u_status (
    .clk(clk), .rst_n(rst_n), .upd_i(exec_i), .fl_i(fl), .mk_i(mk),
    .fctl_i(fctl_e'(fctl_i)), .ld_i(ld_i), .ld_data_i(ld_data_i),
    .push_b_i(push_b_i), .c_o(c_cur), .v_o(v_cur), .byte_o(status_o)
  );

  assign result_o = res;
  assign flags_o  = fl;
  assign wmask_o  = mk;

endmodule

// File: rtl/alu8_core_chk.sv
module alu8_core_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [3:0]       op_i,
  input logic [WIDTH-1:0] reg_i,
  input logic [WIDTH-1:0] mem_i,
  input logic             exec_i,
  input logic [2:0]       fctl_i,
  input logic             ld_i,
  input logic [7:0]       ld_data_i,
  input logic             push_b_i,
  input logic [WIDTH-1:0] result_o,
  input logic [3:0]       flags_o,
  input logic [3:0]       wmask_o,
  input logic [7:0]       status_o
);

  a_r12_fixed_bit: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[5] == 1'b1);

  a_r12_load_byte: assert property (@(posedge clk) disable iff (!rst_n)
    ld_i |=> (status_o[7:6] == $past(ld_data_i[7:6])) &&
             (status_o[3:0] == $past(ld_data_i[3:0])));

  a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_i && !exec_i && fctl_i == 3'd0) |=>
      $stable({status_o[7:6], status_o[3:0]}));

  a_r9_step_keeps_cv: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_i && exec_i && fctl_i == 3'd0 && (op_i == 4'd11 || op_i == 4'd12)) |=>
      (status_o[0] == $past(status_o[0])) && (status_o[6] == $past(status_o[6])));

  a_r5_cmp_keeps_reg: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 4'd5) |-> (result_o == reg_i));

  a_r6_bit_sources: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 4'd6) |-> (result_o == reg_i) && (flags_o[3] == mem_i[WIDTH-1]) &&
                       (flags_o[2] == mem_i[WIDTH-2]));

  a_r7_lsr_clears_n: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 4'd8) |-> !flags_o[3]);

  a_r11_setc: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_i && fctl_i == 3'd1) |=> status_o[0]);

  a_r10_mask_commit: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_i && exec_i && fctl_i == 3'd0 && wmask_o[1]) |=>
      status_o[1] == $past(flags_o[1]));

endmodule

bind alu8_core alu8_core_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/alu8_core_test.sv
module alu8_core_test;

  localparam int W  = 8;
  localparam int NV = 29;

  // {op, reg, mem, cin, result, flags(NVZC), mask(NVZC)}
  localparam logic [36:0] VEC [NV] = '{
    {4'd0,  8'h50, 8'h50, 1'b0, 8'hA0, 4'hC, 4'hF},
    {4'd0,  8'hFF, 8'h01, 1'b0, 8'h00, 4'h3, 4'hF},
    {4'd0,  8'h7F, 8'h00, 1'b1, 8'h80, 4'hC, 4'hF},
    {4'd0,  8'hD0, 8'h90, 1'b0, 8'h60, 4'h5, 4'hF},
    {4'd1,  8'h50, 8'hF0, 1'b1, 8'h60, 4'h0, 4'hF},
    {4'd1,  8'h50, 8'hB0, 1'b1, 8'hA0, 4'hC, 4'hF},
    {4'd1,  8'h05, 8'h05, 1'b1, 8'h00, 4'h3, 4'hF},
    {4'd1,  8'h05, 8'h05, 1'b0, 8'hFF, 4'h8, 4'hF},
    {4'd2,  8'hF0, 8'h0F, 1'b0, 8'h00, 4'h2, 4'hA},
    {4'd3,  8'h80, 8'h01, 1'b0, 8'h81, 4'h8, 4'hA},
    {4'd4,  8'hFF, 8'hFF, 1'b1, 8'h00, 4'h2, 4'hA},
    {4'd4,  8'h5A, 8'h0F, 1'b0, 8'h55, 4'h0, 4'hA},
    {4'd5,  8'h40, 8'h40, 1'b0, 8'h40, 4'h3, 4'hB},
    {4'd5,  8'h10, 8'h20, 1'b1, 8'h10, 4'h8, 4'hB},
    {4'd5,  8'h20, 8'h10, 1'b0, 8'h20, 4'h1, 4'hB},
    {4'd6,  8'h01, 8'hC0, 1'b0, 8'h01, 4'hE, 4'hE},
    {4'd6,  8'h0F, 8'h01, 1'b1, 8'h0F, 4'h0, 4'hE},
    {4'd7,  8'h00, 8'h81, 1'b0, 8'h02, 4'h1, 4'hB},
    {4'd8,  8'h00, 8'h01, 1'b1, 8'h00, 4'h3, 4'hB},
    {4'd8,  8'hFF, 8'h80, 1'b0, 8'h40, 4'h0, 4'hB},
    {4'd9,  8'h00, 8'h80, 1'b1, 8'h01, 4'h1, 4'hB},
    {4'd9,  8'h00, 8'h40, 1'b0, 8'h80, 4'h8, 4'hB},
    {4'd10, 8'h00, 8'h01, 1'b1, 8'h80, 4'h9, 4'hB},
    {4'd10, 8'h00, 8'h02, 1'b0, 8'h01, 4'h0, 4'hB},
    {4'd11, 8'h00, 8'hFF, 1'b1, 8'h00, 4'h2, 4'hA},
    {4'd12, 8'h00, 8'h00, 1'b1, 8'hFF, 4'h8, 4'hA},
    {4'd15, 8'h77, 8'h00, 1'b0, 8'h00, 4'h2, 4'hA},
    {4'd14, 8'h33, 8'h99, 1'b1, 8'h33, 4'h0, 4'h0},
    {4'd0,  8'h00, 8'h00, 1'b1, 8'h01, 4'h0, 4'hF}
  };

  logic         clk;
  logic         rst_n;
  logic [3:0]   op_i;
  logic [W-1:0] reg_i, mem_i;
  logic         exec_i;
  logic [2:0]   fctl_i;
  logic         ld_i;
  logic [7:0]   ld_data_i;
  logic         push_b_i;
  logic [W-1:0] result_o;
  logic [3:0]   flags_o, wmask_o;
  logic [7:0]   status_o;

  int  n_chk  = 0;
  int  n_fail = 0;
  bit  done   = 0;

  alu8_core #(.WIDTH(W)) uut (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .reg_i(reg_i), .mem_i(mem_i),
    .exec_i(exec_i), .fctl_i(fctl_i), .ld_i(ld_i), .ld_data_i(ld_data_i),
    .push_b_i(push_b_i), .result_o(result_o), .flags_o(flags_o),
    .wmask_o(wmask_o), .status_o(status_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic string op_tag(input logic [3:0] op);
    case (op)
      4'd0:                 return "R2";
      4'd1:                 return "R3";
      4'd2, 4'd3, 4'd4, 4'd15: return "R4";
      4'd5:                 return "R5";
      4'd6:                 return "R6";
      4'd7, 4'd8:           return "R7";
      4'd9, 4'd10:          return "R8";
      4'd11, 4'd12:         return "R9";
      default:              return "R10";
    endcase
  endfunction

  task automatic idle_inputs();
    op_i = 4'd14; reg_i = '0; mem_i = '0;
    exec_i = 1'b0; fctl_i = 3'd0; ld_i = 1'b0; ld_data_i = 8'h00;
  endtask

  task automatic run_vec(input int k);
    logic [36:0] v;
    logic [7:0]  old, exp;
    v = VEC[k];
    @(negedge clk);
    idle_inputs();
    fctl_i = v[16] ? 3'd1 : 3'd2;
    @(negedge clk);
    fctl_i = 3'd0;
    op_i = v[36:33]; reg_i = v[32:25]; mem_i = v[24:17];
    #1;
    check($sformatf("%s result vec %0d", op_tag(v[36:33]), k), 32'(result_o), 32'(v[15:8]));
    check($sformatf("%s flags vec %0d", op_tag(v[36:33]), k), 32'(flags_o & v[3:0]), 32'(v[7:4]));
    check($sformatf("%s mask vec %0d", op_tag(v[36:33]), k), 32'(wmask_o), 32'(v[3:0]));
    old = status_o;
    exp = old;
    if (v[0]) exp[0] = v[4];
    if (v[1]) exp[1] = v[5];
    if (v[2]) exp[6] = v[6];
    if (v[3]) exp[7] = v[7];
    exec_i = 1'b1;
    @(negedge clk);
    exec_i = 1'b0;
    op_i = 4'd14;
    #1;
    check($sformatf("R10 status commit vec %0d", k), 32'(status_o), 32'(exp));
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R1 watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    idle_inputs();
    push_b_i = 1'b0;
    rst_n = 1'b0;
    #12;
    check("R1 reset status", 32'(status_o), 32'h24);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 status after release", 32'(status_o), 32'h24);
    push_b_i = 1'b1;
    #1;
    check("R12 push bit shown", 32'(status_o), 32'h34);
    push_b_i = 1'b0;

    for (int k = 0; k < NV; k++) run_vec(k);

    // R12: whole-byte load, bits 4 and 5 ignored
    @(negedge clk); idle_inputs(); ld_i = 1'b1; ld_data_i = 8'hFF;
    @(negedge clk); ld_i = 1'b0; #1;
    check("R12 load all ones", 32'(status_o), 32'hEF);
    @(negedge clk); ld_i = 1'b1; ld_data_i = 8'h10;
    @(negedge clk); ld_i = 1'b0; #1;
    check("R12 load ignores bit4", 32'(status_o), 32'h20);
    // R12: load wins over exec and flag command
    @(negedge clk); ld_i = 1'b1; ld_data_i = 8'h00; fctl_i = 3'd1;
    op_i = 4'd0; reg_i = 8'hFF; mem_i = 8'h01; exec_i = 1'b1;
    @(negedge clk); idle_inputs(); #1;
    check("R12 load priority", 32'(status_o), 32'h20);

    // R10: exec low leaves status alone
    @(negedge clk); op_i = 4'd0; reg_i = 8'h80; mem_i = 8'h80; exec_i = 1'b0;
    @(negedge clk); #1;
    check("R10 no exec no change", 32'(status_o), 32'h20);
    idle_inputs();

    // R11: flag commands
    @(negedge clk); fctl_i = 3'd3;
    @(negedge clk); fctl_i = 3'd5; #1;
    check("R11 set I", 32'(status_o), 32'h24);
    @(negedge clk); fctl_i = 3'd0; #1;
    check("R11 set D", 32'(status_o), 32'h2C);
    // decimal flag does not change add
    op_i = 4'd0; reg_i = 8'h09; mem_i = 8'h01; #1;
    check("R11 binary add with D set", 32'(result_o), 32'h0A);
    op_i = 4'd14;
    @(negedge clk); fctl_i = 3'd6;
    @(negedge clk); fctl_i = 3'd4;
    @(negedge clk); fctl_i = 3'd0; #1;
    check("R11 clear D and I", 32'(status_o), 32'h20);
    @(negedge clk); ld_i = 1'b1; ld_data_i = 8'h40;
    @(negedge clk); ld_i = 1'b0; fctl_i = 3'd7;
    @(negedge clk); fctl_i = 3'd0; #1;
    check("R11 clear V", 32'(status_o), 32'h20);
    // flag command overrides the operation's carry write
    @(negedge clk); op_i = 4'd0; reg_i = 8'hFF; mem_i = 8'h02; exec_i = 1'b1; fctl_i = 3'd2;
    @(negedge clk); idle_inputs(); #1;
    check("R11 clear C beats add carry", 32'(status_o[0]), 32'h0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule